// File: doc/BRIEF.md
# Serial Flash Erase Region Planner

This block accepts an erase request made of a byte offset and a byte length and breaks it into a series of erase commands for a serial NOR flash. At each step it picks the largest erase unit that fits: a 64 KiB sector, a block, or a page. A unit fits when the remaining length is at least the unit size and the current offset is a multiple of that unit. When the request covers the whole device, the block sends a single four-byte whole-chip erase frame instead.

Each command goes out one byte at a time through a byte-level SPI port. That port has a valid/ready send side and a returned byte for every byte sent. After every command the planner reads the status register repeatedly until the device reports ready. Only then does it move the offset forward and pick the next unit. A request that is out of range or not page-aligned is rejected before any byte is sent. An error reported by the SPI engine ends the request at once.

The page size, block size and device size are parameters. The sector size is fixed at 64 KiB. The block size and page size must be powers of two. A new request is accepted only while the block is idle.

Top module: `erase_region_planner`

## Requirements
- R1: A request with offset plus size greater than the device size sets `invalid`, and no SPI byte is sent.
- R2: A request whose offset or size is not a multiple of the page size sets `invalid`, and no SPI byte is sent.
- R3: A request whose size equals the device size sends exactly one four-byte frame, 0xC7 0x94 0x80 0x9A in that order, then waits for ready and sets `done`.
- R4: For any other request, each step tries the units in this order: sector (0x10000 bytes), then block, then page. The first unit chosen is one where the remaining size is at least the unit and the offset is a multiple of it. After the command completes, the offset grows by the unit and the remaining size shrinks by it.
- R5: An erase frame is four bytes long. The first byte is the opcode: 0x7C for a sector, 0x50 for a block, 0x81 for a page. The next three bytes are the offset, most significant byte first. `spi_tx_last` is high on the fourth byte. A byte that is offered stays unchanged until it is accepted.
- R6: After each erase frame, the block sends status-read frames of three bytes (0xD7, 0x00, 0x00). The byte returned for the second byte of each frame is the low status byte. Polling repeats until bit 7 of that byte is 1. No other status bit matters, and the next erase frame starts only after ready is seen.
- R7: A returned byte with `spi_rx_err` high ends the request. `io_error` is set, `done` stays low, and no further byte is sent.
- R8: `done` is set when the remaining size reaches zero, including for a zero-size request. `done`, `invalid` and `io_error` hold until the next accepted request clears them. `busy` is high while the request is in progress.
- R9: After reset, `busy`, `done`, `invalid`, `io_error` and `spi_tx_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (taken when not busy) |
| req_offset | input | REQ_W | Byte offset of the region |
| req_size | input | REQ_W | Byte length of the region |
| busy | output | 1 | Request in progress |
| done | output | 1 | Last request completed |
| invalid | output | 1 | Last request rejected |
| io_error | output | 1 | Last request ended by an SPI error |
| spi_tx_valid | output | 1 | Byte offered to the SPI engine |
| spi_tx_ready | input | 1 | SPI engine accepts the offered byte |
| spi_tx_byte | output | 8 | Byte to send |
| spi_tx_last | output | 1 | Offered byte ends the frame (chip select released after it) |
| spi_rx_valid | input | 1 | Byte returned for the last accepted byte |
| spi_rx_byte | input | 8 | Returned byte |
| spi_rx_err | input | 1 | Transfer of that byte failed |

## Verification
Rejection and the zero-size case take effect at the same clock edge that accepts the request. So `invalid` or `done` can be read at the falling edge right after the request pulse, and `busy` never rises. Every other result is due one clock after the final returned status byte that shows ready, or one clock after the failing byte: the sequencer first flags the frame end and the planner reacts on the next edge. The directed tasks therefore wait on falling edges until `busy` drops and only then compare the flags. They then compare the full logged byte stream, frame by frame, with a stream built from the requirements. The SPI model stalls every byte for one cycle and reports busy (0x7F) for two polls before ready (0x80). This makes both the hold rule and the ready-bit test visible.

// File: rtl/erase_plan_pkg.sv
package erase_plan_pkg;
  localparam int unsigned SECTOR_BYTES = 65536;
  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_SECTOR = 8'h7C;
  localparam logic [7:0] OP_BLOCK  = 8'h50;
  localparam logic [7:0] OP_PAGE   = 8'h81;
  localparam logic [7:0] OP_STATUS = 8'hD7;
  localparam logic [31:0] WHOLE_CHIP_FRAME = 32'hC794_809A;
  localparam int RDY_BIT = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PICK,
    ST_CMD,
    ST_POLL
  } plan_state_t;
endpackage

// File: rtl/erase_req_check.sv
module erase_req_check #(
  parameter int unsigned REQ_W      = 32,
  parameter int unsigned CHIP_BYTES = 1048576,
  parameter int unsigned PAGE_BYTES = 256
) (
  input  logic [REQ_W-1:0] offset,
  input  logic [REQ_W-1:0] size,
  output logic             reject,
  output logic             whole,
  output logic             empty
);
  localparam int PG_LG = $clog2(PAGE_BYTES);

  logic [REQ_W:0] end_addr;
  logic           out_of_range;
  logic           misaligned;

  always_comb begin
    end_addr     = {1'b0, offset} + {1'b0, size};
    out_of_range = end_addr > (REQ_W+1)'(CHIP_BYTES);
    misaligned   = (offset[PG_LG-1:0] != '0) || (size[PG_LG-1:0] != '0);
    reject       = out_of_range || misaligned;
    whole        = size == REQ_W'(CHIP_BYTES);
    empty        = size == '0;
  end
endmodule

// File: rtl/erase_unit_pick.sv
module erase_unit_pick
  import erase_plan_pkg::*;
#(
  parameter int unsigned SZ_W        = 21,
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter int unsigned PAGE_BYTES  = 256
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [SZ_W-1:0]   remain,
  output logic              hit,
  output logic [7:0]        opcode,
  output logic [SZ_W-1:0]   unit
);
  localparam int N_UNITS = 3;

  logic [N_UNITS-1:0] fits;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    localparam int unsigned U  = (i == 0) ? SECTOR_BYTES :
                                 (i == 1) ? BLOCK_BYTES : PAGE_BYTES;
    localparam int          LG = $clog2(U);
    assign fits[i] = (remain >= SZ_W'(U)) && (offset[LG-1:0] == '0);
  end

  always_comb begin
    hit    = 1'b1;
    opcode = OP_PAGE;
    unit   = SZ_W'(PAGE_BYTES);
    if (fits[0]) begin
      opcode = OP_SECTOR;
      unit   = SZ_W'(SECTOR_BYTES);
    end else if (fits[1]) begin
      opcode = OP_BLOCK;
      unit   = SZ_W'(BLOCK_BYTES);
    end else if (!fits[2]) begin
      hit    = 1'b0;
    end
  end
endmodule

// File: rtl/erase_byte_seq.sv
module erase_byte_seq (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] frame,
  input  logic [2:0]  len,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_err,
  output logic        fin,
  output logic        fin_err,
  output logic [7:0]  stat
);
  logic        active_q;
  logic        rx_phase_q;
  logic [1:0]  idx_q;
  logic [31:0] frame_q;
  logic [2:0]  len_q;
  logic        fin_q;
  logic        fin_err_q;
  logic [7:0]  stat_q;
  logic        at_last;

  assign at_last  = ({1'b0, idx_q} == (len_q - 3'd1));
  assign tx_valid = active_q && !rx_phase_q;
  assign tx_last  = at_last;
  assign fin      = fin_q;
  assign fin_err  = fin_err_q;
  assign stat     = stat_q;

  always_comb begin
    case (idx_q)
      2'd0:    tx_byte = frame_q[31:24];
      2'd1:    tx_byte = frame_q[23:16];
      2'd2:    tx_byte = frame_q[15:8];
      default: tx_byte = frame_q[7:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      rx_phase_q <= 1'b0;
      idx_q      <= '0;
      frame_q    <= '0;
      len_q      <= 3'd4;
      fin_q      <= 1'b0;
      fin_err_q  <= 1'b0;
      stat_q     <= '0;
    end else begin
      fin_q <= 1'b0;
      if (!active_q) begin
        if (start) begin
          active_q   <= 1'b1;
          rx_phase_q <= 1'b0;
          idx_q      <= '0;
          frame_q    <= frame;
          len_q      <= len;
          fin_err_q  <= 1'b0;
        end
      end else if (!rx_phase_q) begin
        if (tx_ready) rx_phase_q <= 1'b1;
      end else if (rx_valid) begin
        if (rx_err) begin
          fin_q     <= 1'b1;
          fin_err_q <= 1'b1;
          active_q  <= 1'b0;
        end else begin
          if (idx_q == 2'd1) stat_q <= rx_byte;
          if (at_last) begin
            fin_q     <= 1'b1;
            fin_err_q <= 1'b0;
            active_q  <= 1'b0;
          end else begin
            idx_q      <= idx_q + 2'd1;
            rx_phase_q <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/erase_region_planner.sv
module erase_region_planner
  import erase_plan_pkg::*;
#(
  parameter int unsigned PAGE_BYTES  = 256,
  parameter int unsigned BLOCK_BYTES = 2048,
  parameter int unsigned CHIP_BYTES  = 1048576,
  parameter int unsigned REQ_W       = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_offset,
  input  logic [REQ_W-1:0] req_size,
  output logic             busy,
  output logic             done,
  output logic             invalid,
  output logic             io_error,
  output logic             spi_tx_valid,
  input  logic             spi_tx_ready,
  output logic [7:0]       spi_tx_byte,
  output logic             spi_tx_last,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx_byte,
  input  logic             spi_rx_err
);
  localparam int SZ_W = $clog2(CHIP_BYTES + 1);

  plan_state_t       state_q;
  logic [ADDR_W-1:0] off_q;
  logic [SZ_W-1:0]   rem_q;
  logic [SZ_W-1:0]   unit_q;
  logic              chip_q;
  logic              done_q, invalid_q, io_error_q;

  logic              rq_reject, rq_whole, rq_empty;
  logic              pick_hit;
  logic [7:0]        pick_op;
  logic [SZ_W-1:0]   pick_unit;
  logic              seq_start;
  logic [31:0]       seq_frame;
  logic [2:0]        seq_len;
  logic              seq_fin, seq_fin_err;
  logic [7:0]        seq_stat;
  logic              ready_seen;

  erase_req_check #(
    .REQ_W(REQ_W), .CHIP_BYTES(CHIP_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) check_i (
    .offset(req_offset), .size(req_size),
    .reject(rq_reject), .whole(rq_whole), .empty(rq_empty)
  );

  erase_unit_pick #(
    .SZ_W(SZ_W), .BLOCK_BYTES(BLOCK_BYTES), .PAGE_BYTES(PAGE_BYTES)
  ) pick_i (
    .offset(off_q), .remain(rem_q),
    .hit(pick_hit), .opcode(pick_op), .unit(pick_unit)
  );

  erase_byte_seq seq_i (
    .clk(clk), .rst(rst),
    .start(seq_start), .frame(seq_frame), .len(seq_len),
    .tx_valid(spi_tx_valid), .tx_ready(spi_tx_ready),
    .tx_byte(spi_tx_byte), .tx_last(spi_tx_last),
    .rx_valid(spi_rx_valid), .rx_byte(spi_rx_byte), .rx_err(spi_rx_err),
    .fin(seq_fin), .fin_err(seq_fin_err), .stat(seq_stat)
  );

  assign ready_seen = seq_stat[RDY_BIT];
  assign busy       = state_q != ST_IDLE;
  assign done       = done_q;
  assign invalid    = invalid_q;
  assign io_error   = io_error_q;

  // Frame launch: whole-chip, unit erase, or status poll.
  always_comb begin
    seq_start = 1'b0;
    seq_frame = '0;
    seq_len   = 3'd4;
    case (state_q)
      ST_IDLE: if (req_valid && !rq_reject && !rq_empty && rq_whole) begin
        seq_start = 1'b1;
        seq_frame = WHOLE_CHIP_FRAME;
      end
      ST_PICK: if (pick_hit) begin
        seq_start = 1'b1;
        seq_frame = {pick_op, off_q};
      end
      ST_CMD: if (seq_fin && !seq_fin_err) begin
        seq_start = 1'b1;
        seq_frame = {OP_STATUS, 24'h0};
        seq_len   = 3'd3;
      end
      default: if (seq_fin && !seq_fin_err && !ready_seen) begin
        seq_start = 1'b1;
        seq_frame = {OP_STATUS, 24'h0};
        seq_len   = 3'd3;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      off_q      <= '0;
      rem_q      <= '0;
      unit_q     <= '0;
      chip_q     <= 1'b0;
      done_q     <= 1'b0;
      invalid_q  <= 1'b0;
      io_error_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          done_q     <= 1'b0;
          invalid_q  <= 1'b0;
          io_error_q <= 1'b0;
          if (rq_reject) begin
            invalid_q <= 1'b1;
          end else if (rq_empty) begin
            done_q <= 1'b1;
          end else begin
            off_q   <= req_offset[ADDR_W-1:0];
            rem_q   <= req_size[SZ_W-1:0];
            chip_q  <= rq_whole;
            state_q <= rq_whole ? ST_CMD : ST_PICK;
          end
        end
        ST_PICK: begin
          if (pick_hit) begin
            unit_q  <= pick_unit;
            state_q <= ST_CMD;
          end else begin
            invalid_q <= 1'b1;
            state_q   <= ST_IDLE;
          end
        end
        ST_CMD: if (seq_fin) begin
          if (seq_fin_err) begin
            io_error_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else begin
            state_q <= ST_POLL;
          end
        end
        default: if (seq_fin) begin
          if (seq_fin_err) begin
            io_error_q <= 1'b1;
            state_q    <= ST_IDLE;
          end else if (ready_seen) begin
            if (chip_q || rem_q == unit_q) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              off_q   <= off_q + ADDR_W'(unit_q);
              rem_q   <= rem_q - unit_q;
              state_q <= ST_PICK;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/erase_region_planner_chk.sv
module erase_region_planner_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       invalid,
  input logic       io_error,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_byte,
  input logic       tx_last,
  input logic       rx_valid,
  input logic       rx_err
);
  a_r5_byte_hold: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

  a_r9_idle_silent: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tx_valid);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, invalid, io_error}));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r7_error_stops: assert property (@(posedge clk) disable iff (rst)
    busy && rx_valid && rx_err |=> ##1 (io_error && !busy));

  a_r1_reject_no_work: assert property (@(posedge clk) disable iff (rst)
    invalid |-> !busy && !tx_valid);
endmodule

bind erase_region_planner erase_region_planner_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .invalid(invalid),
  .io_error(io_error), .tx_valid(spi_tx_valid), .tx_ready(spi_tx_ready),
  .tx_byte(spi_tx_byte), .tx_last(spi_tx_last),
  .rx_valid(spi_rx_valid), .rx_err(spi_rx_err)
);

// File: tb/erase_region_planner_tb_top.sv
module erase_region_planner_tb_top;
  localparam int unsigned CHIP = 1048576;
  localparam int BUSY_POLLS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_offset = '0;
  logic [31:0] req_size = '0;
  logic        busy, done, invalid, io_error;
  logic        spi_tx_valid, spi_tx_last;
  logic [7:0]  spi_tx_byte;
  logic        spi_tx_ready = 1'b0;
  logic        spi_rx_valid = 1'b0;
  logic [7:0]  spi_rx_byte = '0;
  logic        spi_rx_err = 1'b0;

  int errs = 0;
  int checks = 0;

  logic [7:0] log_b [0:255];
  logic [7:0] exp_b [0:255];
  int nlog = 0;
  int nexp = 0;
  int err_at = -1;

  always #5 clk = ~clk;

  erase_region_planner dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_offset(req_offset),
    .req_size(req_size), .busy(busy), .done(done), .invalid(invalid),
    .io_error(io_error), .spi_tx_valid(spi_tx_valid), .spi_tx_ready(spi_tx_ready),
    .spi_tx_byte(spi_tx_byte), .spi_tx_last(spi_tx_last),
    .spi_rx_valid(spi_rx_valid), .spi_rx_byte(spi_rx_byte), .spi_rx_err(spi_rx_err)
  );

  // SPI engine and flash status model.
  initial begin
    logic       rx_pend, stalled, poll_frame, err_next;
    logic [7:0] rx_next;
    int         pos, polls_done;
    rx_pend = 0; stalled = 0; poll_frame = 0; err_next = 0;
    rx_next = '0; pos = 0; polls_done = 0;
    forever begin
      @(negedge clk);
      spi_tx_ready = 1'b0;
      spi_rx_valid = 1'b0;
      spi_rx_err   = 1'b0;
      if (rx_pend) begin
        spi_rx_valid = 1'b1;
        spi_rx_byte  = rx_next;
        spi_rx_err   = err_next;
        rx_pend = 0;
      end else if (spi_tx_valid) begin
        if (!stalled) begin
          stalled = 1;
        end else begin
          stalled = 0;
          spi_tx_ready = 1'b1;
          if (nlog < 256) log_b[nlog] = spi_tx_byte;
          if (pos == 0) poll_frame = (spi_tx_byte == 8'hD7);
          rx_next = 8'h00;
          if (poll_frame && pos == 1)
            rx_next = (polls_done >= BUSY_POLLS) ? 8'h80 : 8'h7F;
          err_next = (nlog == err_at);
          if (spi_tx_last) begin
            pos = 0;
            if (poll_frame) polls_done++;
            else polls_done = 0;
          end else begin
            pos++;
          end
          nlog++;
          rx_pend = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic add_byte(input logic [7:0] b);
    exp_b[nexp] = b;
    nexp++;
  endtask

  task automatic add_polls();
    for (int p = 0; p <= BUSY_POLLS; p++) begin
      add_byte(8'hD7); add_byte(8'h00); add_byte(8'h00);
    end
  endtask

  task automatic add_cmd(input logic [7:0] op, input logic [23:0] off);
    add_byte(op); add_byte(off[23:16]); add_byte(off[15:8]); add_byte(off[7:0]);
    add_polls();
  endtask

  task automatic cmp_stream(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < nexp; i++)
      if (bad < 0 && i < nlog && log_b[i] !== exp_b[i]) bad = i;
    chk(nlog == nexp, req, "byte count", nlog, nexp);
    if (bad >= 0) chk(1'b0, req, $sformatf("byte %0d", bad), log_b[bad], exp_b[bad]);
    else chk(1'b1, req, "byte stream", 0, 0);
  endtask

  task automatic run(input int off, input int size);
    nlog = 0;
    nexp = 0;
    @(negedge clk);
    req_offset = off;
    req_size   = size;
    req_valid  = 1'b1;
    @(negedge clk);
    req_valid  = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!busy && !done && !invalid && !io_error && !spi_tx_valid, "R9",
        "outputs after reset", {busy, done, invalid, io_error, spi_tx_valid}, 0);
  endtask

  task automatic t_range();
    run(32'h000F_FF00, 32'h200);
    chk(invalid && !done, "R1", "invalid flag", {invalid, done}, 2'b10);
    chk(nlog == 0, "R1", "bytes sent", nlog, 0);
  endtask

  task automatic t_align();
    run(32'h80, 32'h100);
    chk(invalid && nlog == 0, "R2", "offset misaligned", {invalid, 8'(nlog)}, 9'h100);
    run(32'h0, 32'h180);
    chk(invalid && nlog == 0, "R2", "size misaligned", {invalid, 8'(nlog)}, 9'h100);
  endtask

  task automatic t_chip();
    bit seen_busy;
    nlog = 0;
    nexp = 0;
    @(negedge clk);
    req_offset = 0; req_size = CHIP; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen_busy = busy;
    while (busy) @(negedge clk);
    chk(seen_busy, "R8", "busy during chip erase", seen_busy, 1);
    add_byte(8'hC7); add_byte(8'h94); add_byte(8'h80); add_byte(8'h9A);
    add_polls();
    cmp_stream("R3");
    chk(done && !io_error, "R3", "done after chip erase", {done, io_error}, 2'b10);
  endtask

  task automatic t_mixed();
    run(32'h0000_F800, 32'h0001_0900);
    add_cmd(8'h50, 24'h00F800);
    add_cmd(8'h7C, 24'h010000);
    add_cmd(8'h81, 24'h020000);
    cmp_stream("R4 R5 R6 block-sector-page");
    chk(done, "R8", "done after mixed", done, 1);
  endtask

  task automatic t_page_block();
    run(32'h700, 32'h900);
    add_cmd(8'h81, 24'h000700);
    add_cmd(8'h50, 24'h000800);
    cmp_stream("R4 page-then-block");
    chk(done, "R8", "done after page/block", done, 1);
  endtask

  task automatic t_sectors();
    run(32'h0003_0000, 32'h0002_0000);
    add_cmd(8'h7C, 24'h030000);
    add_cmd(8'h7C, 24'h040000);
    cmp_stream("R5 two sectors");
  endtask

  task automatic t_error();
    err_at = 5;
    run(32'h0, 32'h0002_0000);
    err_at = -1;
    add_byte(8'h7C); add_byte(8'h00); add_byte(8'h00); add_byte(8'h00);
    add_byte(8'hD7); add_byte(8'h00);
    cmp_stream("R7 stop after error");
    chk(io_error && !done, "R7", "error flags", {io_error, done}, 2'b10);
  endtask

  task automatic t_zero();
    run(32'h100, 32'h0);
    chk(done && !io_error && !invalid, "R8", "zero size done and flags cleared",
        {done, io_error, invalid}, 3'b100);
    chk(nlog == 0, "R8", "zero size bytes", nlog, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_range();
    t_align();
    t_chip();
    t_mixed();
    t_page_block();
    t_sectors();
    t_error();
    t_zero();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule